// File: doc/BRIEF.md
# Delayed-LMS Weight Update Array

This block keeps the coefficient set of a pipelined least-mean-square adaptive FIR filter and adapts it in place. The error term reaches the block several cycles after the filter output that produced it, so each lane pairs that stale error with an input sample delayed by the same amount. The block holds its own sample delay line for this. One sample enters each clock, and the line is long enough (taps plus adaptation delay) to provide the matched old samples.

The step size is a negative power of two. The scaled error is therefore a single arithmetic right shift, formed once and shared by every lane. Each lane multiplies it by its delayed sample, rescales the product to the weight's fixed-point grid and accumulates into its weight with saturation. The weight vector is a registered output. The surrounding filter reads it both for its next error computation and as the base of the next update.

Top module: `dlms_weight_array`

## Requirements
- R1: While `rst` is high at a rising edge, every weight becomes 0 and the sample line is cleared to 0.
- R2: At a rising edge where `err_vld` is low, all weights keep their value, whatever `err_in` and `x_in` carry.
- R3: At a rising edge where `err_vld` is high, lane i becomes sat(w_i + ((s · x_d,i) >>> PROD_SHIFT)). Here s = `err_in` >>> MU_SHIFT, and all values are signed two's complement.
- R4: Both right shifts are arithmetic and round toward minus infinity. For example, `err_in` = -5 with MU_SHIFT = 2 gives s = -2, and s · 127 >>> 7 gives -2.
- R5: The sample x_d,i used by lane i is the value that was on `x_in` at the rising edge ADAPT_DLY + i + 1 edges before the update edge. A sample captured before the last reset counts as 0.
- R6: A sum above 2^(WW-1)-1 gives 2^(WW-1)-1, and a sum below -2^(WW-1) gives -2^(WW-1). There is no wrap-around.
- R7: Lane i is presented on `w_out[i*WW +: WW]`. All lanes use the same scaled error in the same cycle, and each lane's result depends only on its own weight and its own sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| x_in | input | XW | New input sample, signed, one per clock |
| err_in | input | EW | Delayed error, signed |
| err_vld | input | 1 | Qualifies `err_in`; update happens only when high |
| w_out | output | NTAPS*WW | Registered weights, lane i at bits i*WW +: WW |

## Verification
Several properties are checked on every cycle. Weights hold whenever the error is not valid. A valid error that shifts down to zero leaves every weight unchanged. Reset clears the vector. The first ADAPT_DLY+1 updates after reset cannot move any weight, because the matched samples are still the cleared ones. The exact arithmetic (rounding of both shifts, the stale-sample pairing per lane and clipping at both rails) is shown only by the bench scenarios. These compare every lane after every edge against an independent model of the recursion, in a system-identification run, an error sweep and a saturation run.

// File: rtl/dlms_pkg.sv
package dlms_pkg;

  typedef enum logic [1:0] {
    SAT_PASS = 2'd0,
    SAT_HIGH = 2'd1,
    SAT_LOW  = 2'd2
  } sat_e;

  // Decide how a wide sum maps back onto the narrow weight.
  // uniform: all bits from the weight sign bit upward agree.
  function automatic sat_e sat_classify(input logic neg, input logic uniform);
    if (uniform)  return SAT_PASS;
    else if (neg) return SAT_LOW;
    else          return SAT_HIGH;
  endfunction

endpackage

// File: rtl/dlms_sample_line.sv
module dlms_sample_line #(
  parameter int XW    = 8,
  parameter int DEPTH = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [XW-1:0]         x_in,
  output logic [DEPTH*XW-1:0]   taps
);

  logic [XW-1:0] stage [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= '0;
    else     stage[0] <= x_in;
  end

  generate
    for (genvar k = 1; k < DEPTH; k++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage[k] <= '0;
        else     stage[k] <= stage[k-1];
      end
    end
    for (genvar k = 0; k < DEPTH; k++) begin : g_out
      assign taps[k*XW +: XW] = stage[k];
    end
  endgenerate

endmodule

// File: rtl/dlms_err_scale.sv
module dlms_err_scale #(
  parameter int EW       = 12,
  parameter int MU_SHIFT = 2
) (
  input  logic signed [EW-1:0] err_in,
  output logic signed [EW-1:0] err_scaled
);

  // Step size 2^-MU_SHIFT: one shared arithmetic shift for every lane.
  assign err_scaled = err_in >>> MU_SHIFT;

endmodule

// File: rtl/dlms_mac_lane.sv
module dlms_mac_lane
  import dlms_pkg::*;
#(
  parameter int WW         = 8,
  parameter int XW         = 8,
  parameter int EW         = 12,
  parameter int PROD_SHIFT = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [EW-1:0] s_err,
  input  logic signed [XW-1:0] x_d,
  output logic signed [WW-1:0] w
);

  localparam int PW = EW + XW;
  localparam int SW = PW + 1;
  localparam int UW = SW - WW + 1;

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] incr;
  logic signed [SW-1:0] sum;
  logic [UW-1:0]        upper;
  logic                 uniform;
  sat_e                 mode;

  assign prod    = s_err * x_d;
  assign incr    = prod >>> PROD_SHIFT;
  assign sum     = SW'(w) + SW'(incr);
  assign upper   = sum[SW-1:WW-1];
  assign uniform = (upper == '0) || (upper == '1);
  assign mode    = sat_classify(sum[SW-1], uniform);

  always_ff @(posedge clk) begin
    if (rst) begin
      w <= '0;
    end else if (en) begin
      case (mode)
        SAT_HIGH: w <= {1'b0, {(WW-1){1'b1}}};
        SAT_LOW:  w <= {1'b1, {(WW-1){1'b0}}};
        default:  w <= sum[WW-1:0];
      endcase
    end
  end

endmodule

// File: rtl/dlms_weight_array.sv
module dlms_weight_array #(
  parameter int NTAPS      = 4,
  parameter int WW         = 8,
  parameter int XW         = 8,
  parameter int EW         = 12,
  parameter int MU_SHIFT   = 2,
  parameter int PROD_SHIFT = 7,
  parameter int ADAPT_DLY  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [XW-1:0]    x_in,
  input  logic signed [EW-1:0]    err_in,
  input  logic                    err_vld,
  output logic [NTAPS*WW-1:0]     w_out
);

  localparam int LINE = NTAPS + ADAPT_DLY;

  logic [LINE*XW-1:0]   taps;
  logic signed [EW-1:0] err_scaled;

  dlms_sample_line #(.XW(XW), .DEPTH(LINE)) u_line (
    .clk  (clk),
    .rst  (rst),
    .x_in (x_in),
    .taps (taps)
  );

  dlms_err_scale #(.EW(EW), .MU_SHIFT(MU_SHIFT)) u_scale (
    .err_in     (err_in),
    .err_scaled (err_scaled)
  );

  generate
    for (genvar i = 0; i < NTAPS; i++) begin : g_lane
      logic signed [XW-1:0] x_d;
      logic signed [WW-1:0] w_lane;

      // lane i pairs the stale error with the sample ADAPT_DLY+i deep
      assign x_d = taps[(ADAPT_DLY+i)*XW +: XW];

      dlms_mac_lane #(
        .WW(WW), .XW(XW), .EW(EW), .PROD_SHIFT(PROD_SHIFT)
      ) u_lane (
        .clk   (clk),
        .rst   (rst),
        .en    (err_vld),
        .s_err (err_scaled),
        .x_d   (x_d),
        .w     (w_lane)
      );

      assign w_out[i*WW +: WW] = w_lane;
    end
  endgenerate

endmodule

// File: rtl/dlms_weight_array_chk.sv
module dlms_weight_array_chk #(
  parameter int NTAPS      = 4,
  parameter int WW         = 8,
  parameter int XW         = 8,
  parameter int EW         = 12,
  parameter int MU_SHIFT   = 2,
  parameter int PROD_SHIFT = 7,
  parameter int ADAPT_DLY  = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic signed [XW-1:0] x_in,
  input logic signed [EW-1:0] err_in,
  input logic                 err_vld,
  input logic [NTAPS*WW-1:0]  w_out
);

  localparam int CW = $clog2(ADAPT_DLY + 2) + 1;
  localparam logic [CW-1:0] CMAX = CW'(ADAPT_DLY + 1);

  logic [CW-1:0] since_rst;
  logic          unused_ok;

  assign unused_ok = ^{x_in, PROD_SHIFT[0]};

  always_ff @(posedge clk) begin
    if (rst)                    since_rst <= '0;
    else if (since_rst != CMAX) since_rst <= since_rst + 1'b1;
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (w_out == '0));

  assert_hold_without_valid_R2: assert property (@(posedge clk) disable iff (rst)
    !err_vld |=> $stable(w_out));

  assert_zero_step_R3: assert property (@(posedge clk) disable iff (rst)
    (err_vld && ((err_in >>> MU_SHIFT) == '0)) |=> $stable(w_out));

  assert_stale_samples_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (since_rst <= CW'(ADAPT_DLY)) |=> $stable(w_out));

endmodule

bind dlms_weight_array dlms_weight_array_chk #(
  .NTAPS(NTAPS), .WW(WW), .XW(XW), .EW(EW),
  .MU_SHIFT(MU_SHIFT), .PROD_SHIFT(PROD_SHIFT), .ADAPT_DLY(ADAPT_DLY)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .x_in    (x_in),
  .err_in  (err_in),
  .err_vld (err_vld),
  .w_out   (w_out)
);

// File: tb/sim_dlms_weight_array.sv
`timescale 1ns/1ps
module sim_dlms_weight_array;

  localparam int NTAPS = 4;
  localparam int WW    = 8;
  localparam int XW    = 8;
  localparam int EW    = 12;
  localparam int MU    = 2;
  localparam int PS    = 7;
  localparam int N1    = 2;
  localparam int LINE  = NTAPS + N1;
  localparam int WMAX  = (1 << (WW-1)) - 1;
  localparam int WMIN  = -(1 << (WW-1));
  localparam int EMAX  = (1 << (EW-1)) - 1;
  localparam int EMIN  = -(1 << (EW-1));

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic signed [XW-1:0]   x_in = '0;
  logic signed [EW-1:0]   err_in = '0;
  logic                   err_vld = 1'b0;
  logic [NTAPS*WW-1:0]    w_out;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  int xl [LINE];
  int wm [NTAPS];
  int ehist [4096];
  int h [NTAPS] = '{50, -30, 20, -10};
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  dlms_weight_array #(
    .NTAPS(NTAPS), .WW(WW), .XW(XW), .EW(EW),
    .MU_SHIFT(MU), .PROD_SHIFT(PS), .ADAPT_DLY(N1)
  ) u0 (
    .clk(clk), .rst(rst), .x_in(x_in), .err_in(err_in),
    .err_vld(err_vld), .w_out(w_out)
  );

  function automatic int clampw(input int v);
    if (v > WMAX) return WMAX;
    if (v < WMIN) return WMIN;
    return v;
  endfunction

  function automatic int clampe(input int v);
    if (v > EMAX) return EMAX;
    if (v < EMIN) return EMIN;
    return v;
  endfunction

  function automatic int lane_val(input int i);
    logic signed [WW-1:0] t;
    t = w_out[i*WW +: WW];
    return int'(t);
  endfunction

  task automatic check_lanes(input string tag);
    for (int i = 0; i < NTAPS; i++) begin
      compared++;
      if (lane_val(i) != wm[i]) begin
        mismatched++;
        $display("FAIL %s lane %0d: actual %0d expected %0d", tag, i, lane_val(i), wm[i]);
      end
    end
  endtask

  task automatic check_one(input string tag, input int lane, input int expv);
    compared++;
    if (lane_val(lane) != expv) begin
      mismatched++;
      $display("FAIL %s lane %0d: actual %0d expected %0d", tag, lane, lane_val(lane), expv);
    end
  endtask

  // Drive one cycle (called just after a falling edge), update the model
  // for the coming rising edge, then compare at the next falling edge.
  task automatic tick(input int xv, input int ev, input bit vv, input string tag);
    int s;
    x_in    = XW'(xv);
    err_in  = EW'(ev);
    err_vld = vv;
    @(posedge clk);
    if (rst) begin
      for (int k = 0; k < LINE; k++) xl[k] = 0;
      for (int i = 0; i < NTAPS; i++) wm[i] = 0;
    end else begin
      if (vv) begin
        s = ev >>> MU;
        for (int i = 0; i < NTAPS; i++)
          wm[i] = clampw(wm[i] + ((s * xl[N1+i]) >>> PS));
      end
      for (int k = LINE-1; k > 0; k--) xl[k] = xl[k-1];
      xl[0] = xv;
    end
    @(negedge clk);
    check_lanes(tag);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(17, 900, 1'b1, "R1");
    tick(-3, -900, 1'b1, "R1");
    rst = 1'b0;
  endtask

  function automatic int next_x();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return int'($signed(lfsr[7:0])) >>> 1;
  endfunction

  initial begin
    @(negedge clk);
    do_reset();

    // R5: first N1+1 updates see only cleared samples
    for (int n = 0; n < N1 + 1; n++) tick(100, 2000, 1'b1, "R5");
    for (int i = 0; i < NTAPS; i++) check_one("R5 cleared pairing", i, 0);

    // R4: negative error rounds toward minus infinity
    do_reset();
    for (int n = 0; n < LINE; n++) tick(127, 0, 1'b0, "R2");
    tick(127, -5, 1'b1, "R4");
    for (int i = 0; i < NTAPS; i++) check_one("R4 floor rounding", i, -2);

    // R2: errors without valid are ignored
    for (int n = 0; n < 20; n++) tick(next_x(), 1500 - n * 150, 1'b0, "R2");

    // R3/R7: sweep the whole error range with random samples
    for (int e = EMIN; e <= EMAX; e += 37) tick(next_x(), e, 1'b1, "R3 R7 sweep");

    // R6: positive then negative saturation
    do_reset();
    for (int n = 0; n < LINE; n++) tick(127, 0, 1'b0, "R2");
    for (int n = 0; n < 4; n++) tick(127, EMAX, 1'b1, "R6");
    for (int i = 0; i < NTAPS; i++) check_one("R6 high rail", i, WMAX);
    for (int n = 0; n < 4; n++) tick(127, EMIN, 1'b1, "R6");
    for (int i = 0; i < NTAPS; i++) check_one("R6 low rail", i, WMIN);

    // R1 after nonzero weights
    do_reset();
    for (int i = 0; i < NTAPS; i++) check_one("R1 clear", i, 0);

    // R3/R5/R7: system identification with an error delayed N1 cycles
    for (int n = 0; n < 1500; n++) begin
      int xv, ev, d, y;
      bit vv;
      xv = next_x();
      vv = (n >= N1 + 1);
      ev = vv ? ehist[n - N1 - 1] : 0;
      tick(xv, ev, vv, "R3 R5 R7 sysid");
      d = 0;
      y = 0;
      for (int k = 0; k < NTAPS; k++) begin
        d += h[k] * xl[k];
        y += wm[k] * xl[k];
      end
      ehist[n] = clampe((d - y) >>> 5);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog R1-R7 run: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule